// File: doc/BRIEF.md
# Serial ADC Configure-and-Read Sequencer

This block drives an external eight-channel, twelve-bit serial analog-to-digital converter from the master side. A client offers a request made of a logical input number (1 to 4) and a two-bit range code. The sequencer accepts it through a valid/ready handshake and assembles an eight-bit control word. It shifts that word to the converter inside a first chip-select frame. It then keeps chip select high for the conversion time and reads the twelve-bit result inside a second frame. It returns the result as a sixteen-bit value together with a one-cycle valid strobe.

The serial clock comes from a half-period counter on the system clock and rests low between frames. The converter takes outgoing data on the rising serial edge, so the sequencer changes its data line only on falling edges. Incoming data is captured at the end of each low half, just before the rising edge. Logical inputs select converter channels in reverse order, and converter channels 0 to 3 are never addressed. A request with an input number outside 1 to 4 is refused with an error strobe. No frame is started for it.

The control is one state machine with five states. ST_IDLE moves to ST_CFG when a valid request is accepted. ST_CFG moves to ST_CONV after the eighth control bit. ST_CONV moves to ST_READ once the conversion wait has elapsed. ST_READ moves to ST_GAP after the twelfth data bit, and this is also where the result is published. ST_GAP moves back to ST_IDLE after the minimum chip-select-high time.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control word is sent most significant bit first with this layout: bit 7 is a constant 1, bits 6:4 select the converter channel, bit 3 is req_range[1] (range doubling), bit 2 is req_range[0] (bipolar), and bits 1:0 are always 00. Input 2 with range code 00 therefore produces 8'hE0.
- R2: Logical input n (1 to 4) selects converter channel 8-n, so input 1 selects channel 7 and input 4 selects channel 4.
- R3: adc_sclk is low whenever chip select is high. Within a frame, each bit takes SCLK_HALF_CYCLES system cycles low followed by SCLK_HALF_CYCLES cycles high. adc_dout changes only at the start of a frame or at a falling serial edge.
- R4: The configuration frame starts in the cycle after acceptance. adc_cs_n stays low for exactly 16·SCLK_HALF_CYCLES cycles.
- R5: Between the two frames adc_cs_n stays high for max(ceil(CLK_FREQ_HZ·CONV_TIME_NS/1e9), 2·CS_GAP_SCLKS·SCLK_HALF_CYCLES) cycles, which is 455 cycles with the default parameters.
- R6: The read frame lasts 24·SCLK_HALF_CYCLES cycles. adc_din is captured MSB first at the last system edge of each low half, and adc_dout is held at 0 during this frame.
- R7: In the cycle in which chip select rises at the end of the read frame, res_valid is 1 for one cycle. res_data carries the twelve bits sign-extended when req_range[0]=1 and zero-extended when it is 0, and keeps that value until the next result.
- R8: After the read frame, chip select stays high for 2·CS_GAP_SCLKS·SCLK_HALF_CYCLES cycles before the block returns to idle. busy is high from the cycle after acceptance until idle is reached, and req_ready equals the inverse of busy.
- R9: A request held while busy is not taken. It is accepted on the first edge at which req_ready is already 1.
- R10: A request with req_input equal to 0, 5, 6 or 7 raises req_err for the following cycle. No frame starts, and req_ready stays 1.
- R11: During and right after reset, adc_cs_n is 1, adc_sclk, adc_dout, busy, res_valid and req_err are 0, req_ready is 1, and res_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_input | input | 3 | Logical analog input, 1 to 4 legal |
| req_range | input | 2 | Bit 1 doubles the span, bit 0 selects bipolar |
| req_err | output | 1 | One-cycle strobe for an illegal input number |
| busy | output | 1 | Transaction in progress |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_dout | output | 1 | Serial data to the converter |
| adc_din | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 16 | Extended conversion result |

## Verification
Two events can fall in the same cycle. The gap after a read ends and returns the block to idle, while a request that arrived during the transaction is still being held. The bench provokes this by raising req_valid while busy and keeping it high through the whole transaction. The reference model decides on every clock whether the request should be taken on that edge or only on the next one. A second collision comes from back-to-back illegal requests: each must give its own req_err strobe, with no frame in between. Every output is compared against the model cycle by cycle, so a request taken one edge early or late shows up as a chip-select or busy mismatch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CTRL_BITS    = 8;
    localparam int DATA_BITS    = 12;
    localparam int RES_BITS     = 16;
    localparam int ADC_CHANNELS = 8;
    localparam int USED_INPUTS  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_CONV,
        ST_READ,
        ST_GAP
    } seq_state_e;
endpackage

// File: rtl/adc_sclk_timer.sv
module adc_sclk_timer #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic level
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            level <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            level <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            level <= ~level;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the serial clock never runs outside a frame
    assert_level_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !level);
endmodule

// File: rtl/adc_ctrl_encoder.sv
module adc_ctrl_encoder
    import adc_seq_pkg::*;
(
    input  logic [2:0]           chan_in,
    input  logic [1:0]           range_in,
    output logic                 legal,
    output logic [CTRL_BITS-1:0] ctrl_word
);
    logic [2:0] conv_chan;

    assign legal     = (chan_in >= 3'd1) && (int'(chan_in) <= USED_INPUTS);
    assign conv_chan = 3'(ADC_CHANNELS - int'(chan_in));
    assign ctrl_word = {1'b1, conv_chan, range_in[1], range_in[0], 2'b00};

    // R2: a legal input always lands in the upper half of the converter
    always_comb begin
        if (legal) assert_upper_channel_R2: assert (conv_chan[2] == 1'b1);
    end
endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_out,
    input  logic             shift_in,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_out) begin
            q <= {q[WIDTH-2:0], 1'b0};
        end else if (shift_in) begin
            q <= {q[WIDTH-2:0], din};
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CLK_FREQ_HZ      = 50_000_000,
    parameter int SCLK_HALF_CYCLES = 2,
    parameter int CONV_TIME_NS     = 9090,
    parameter int CS_GAP_SCLKS     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_input,
    input  logic [1:0]          req_range,
    output logic                req_err,
    output logic                busy,
    output logic                adc_sclk,
    output logic                adc_cs_n,
    output logic                adc_dout,
    input  logic                adc_din,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data
);
    localparam longint CONV_RAW =
        (longint'(CLK_FREQ_HZ) * CONV_TIME_NS + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int CONV_CYCLES = int'(CONV_RAW);
    localparam int GAP_CYCLES  = 2 * CS_GAP_SCLKS * SCLK_HALF_CYCLES;
    localparam int WAIT_CYCLES = (CONV_CYCLES > GAP_CYCLES) ? CONV_CYCLES : GAP_CYCLES;
    localparam int WCW         = $clog2(WAIT_CYCLES + 1);
    localparam int CFG_HALVES  = 2 * CTRL_BITS;
    localparam int RD_HALVES   = 2 * DATA_BITS;
    localparam int HCW         = $clog2(RD_HALVES + 1);
    localparam int PAD_BITS    = DATA_BITS - CTRL_BITS;
    localparam int EXT_BITS    = RES_BITS - DATA_BITS;

    seq_state_e state_q, state_d;

    logic                 tick, sclk_lvl, frame_on;
    logic [HCW-1:0]       half_q;
    logic [WCW-1:0]       wait_q;
    logic                 enc_ok;
    logic [CTRL_BITS-1:0] enc_word;
    logic [DATA_BITS-1:0] sr_q;
    logic                 bip_q;
    logic                 take, cfg_done, rd_done;

    assign frame_on = (state_q == ST_CFG) || (state_q == ST_READ);
    assign take     = (state_q == ST_IDLE) && req_valid && enc_ok;
    assign cfg_done = (state_q == ST_CFG)  && tick && (half_q == HCW'(CFG_HALVES - 1));
    assign rd_done  = (state_q == ST_READ) && tick && (half_q == HCW'(RD_HALVES - 1));

    adc_ctrl_encoder u_enc (
        .chan_in  (req_input),
        .range_in (req_range),
        .legal    (enc_ok),
        .ctrl_word(enc_word)
    );

    adc_sclk_timer #(.HALF_CYCLES(SCLK_HALF_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (frame_on),
        .tick (tick),
        .level(sclk_lvl)
    );

    adc_bit_shifter #(.WIDTH(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_val ({enc_word, {PAD_BITS{1'b0}}}),
        .shift_out((state_q == ST_CFG) && tick && sclk_lvl),
        .shift_in ((state_q == ST_READ) && tick && !sclk_lvl),
        .din      (adc_din),
        .q        (sr_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take)     state_d = ST_CFG;
            ST_CFG:  if (cfg_done) state_d = ST_CONV;
            ST_CONV: if (wait_q == WCW'(WAIT_CYCLES - 1)) state_d = ST_READ;
            ST_READ: if (rd_done)  state_d = ST_GAP;
            ST_GAP:  if (wait_q == WCW'(GAP_CYCLES - 1))  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // half-bit and wait counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
            wait_q <= '0;
        end else begin
            if (!frame_on)  half_q <= '0;
            else if (tick)  half_q <= half_q + 1'b1;
            if (state_d != state_q) wait_q <= '0;
            else if ((state_q == ST_CONV) || (state_q == ST_GAP)) wait_q <= wait_q + 1'b1;
        end
    end

    // pin-level outputs follow the state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        adc_cs_n  = !frame_on;
        adc_sclk  = sclk_lvl;
        adc_dout  = (state_q == ST_CFG) ? sr_q[DATA_BITS-1] : 1'b0;
    end

    // registered strobes and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_err   <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            bip_q     <= 1'b0;
        end else begin
            req_err   <= (state_q == ST_IDLE) && req_valid && !enc_ok;
            res_valid <= rd_done;
            if (take) bip_q <= req_range[0];
            if (rd_done) begin
                res_data <= bip_q ? {{EXT_BITS{sr_q[DATA_BITS-1]}}, sr_q}
                                  : {{EXT_BITS{1'b0}}, sr_q};
            end
        end
    end

    // cycles chip select has been high, for the conversion-wait check
    logic [WCW-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hi_cnt_q <= '0;
        else if (!adc_cs_n)           hi_cnt_q <= '0;
        else if (hi_cnt_q != WCW'(WAIT_CYCLES)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assert_sclk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);
    assert_dout_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && adc_sclk) |-> $stable(adc_dout));
    assert_conv_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_READ) && $fell(adc_cs_n)) |-> (int'(hi_cnt_q) >= CONV_CYCLES));
    assert_result_at_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n));
    assert_ready_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && busy));
    assert_err_no_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (adc_cs_n && !busy));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int H     = 2;
    localparam int W     = (50 * 9090 + 999) / 1000;
    localparam int G     = 2 * 3 * H;
    localparam int CFGN  = 16 * H;
    localparam int RD0   = CFGN + W;
    localparam int RDEND = RD0 + 24 * H;
    localparam int TEND  = RDEND + G;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_input = 3'd0;
    logic [1:0]  req_range = 2'd0;
    logic        adc_din = 1'b0;
    logic        req_ready, req_err, busy, adc_sclk, adc_cs_n, adc_dout, res_valid;
    logic [15:0] res_data;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    int          mt = -1;
    logic [7:0]  m_byte = 8'h00;
    logic [11:0] m_word = 12'h000;
    logic        m_bip = 1'b0;
    logic        e_err = 1'b0;
    logic        e_rv = 1'b0;
    logic [15:0] e_res = 16'h0000;
    logic [11:0] tb_word = 12'h000;

    always #10 clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_input(req_input), .req_range(req_range), .req_err(req_err), .busy(busy),
        .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .adc_dout(adc_dout), .adc_din(adc_din),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] got,
                       input logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mt = -1; e_err = 1'b0; e_rv = 1'b0; e_res = 16'h0000;
        end else begin
            e_err = 1'b0;
            e_rv  = 1'b0;
            if (mt >= 0) begin
                mt++;
                if (mt == RDEND) begin
                    e_rv  = 1'b1;
                    e_res = m_bip ? {{4{m_word[11]}}, m_word} : {4'h0, m_word};
                end
                if (mt == TEND) mt = -1;
            end else if (req_valid) begin
                if (req_input >= 3'd1 && req_input <= 3'd4) begin
                    mt     = 0;
                    m_byte = {1'b1, 3'(8 - int'(req_input)), req_range, 2'b00};
                    m_bip  = req_range[0];
                    m_word = tb_word;
                end else begin
                    e_err = 1'b1;
                end
            end
        end
    end

    // converter stand-in and per-clock comparison
    always @(negedge clk) begin : cmp
        logic in_cfg, in_rd;
        int   rel;
        in_cfg = (mt >= 0) && (mt < CFGN);
        in_rd  = (mt >= RD0) && (mt < RDEND);
        rel    = in_cfg ? mt : (in_rd ? mt - RD0 : 0);
        adc_din <= in_rd ? m_word[11 - (rel / (2 * H))] : 1'b0;
        chk("R4/R5", "cs_n", 16'(adc_cs_n), 16'(!(in_cfg || in_rd)));
        chk("R3", "sclk", 16'(adc_sclk), 16'((in_cfg || in_rd) ? ((rel / H) % 2) : 0));
        chk("R1/R2", "dout", 16'(adc_dout), 16'(in_cfg ? m_byte[7 - (rel / (2 * H))] : 1'b0));
        chk("R8", "busy", 16'(busy), 16'(mt >= 0));
        chk("R8/R9", "ready", 16'(req_ready), 16'(mt < 0));
        chk("R10", "err", 16'(req_err), 16'(e_err));
        chk("R7", "res_valid", 16'(res_valid), 16'(e_rv));
        chk("R6/R7", "res_data", res_data, e_res);
    end

    task automatic send(input logic [2:0] inp, input logic [1:0] rng, input logic [11:0] word);
        @(negedge clk);
        req_valid = 1'b1;
        req_input = inp;
        req_range = rng;
        tb_word   = word;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_txn();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset cs_n", 16'(adc_cs_n), 16'd1);
        chk("R11", "reset ready", 16'(req_ready), 16'd1);
        chk("R11", "reset res_data", res_data, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "post-reset busy", 16'(busy), 16'd0);

        send(3'd2, 2'b00, 12'hABC); finish_txn();   // R1: byte E0, zero extension
        send(3'd1, 2'b11, 12'h800); finish_txn();   // R2/R7: channel 7, sign extension
        send(3'd4, 2'b01, 12'h7FF); finish_txn();   // R2/R7: channel 4, positive bipolar
        send(3'd3, 2'b10, 12'hFFF); finish_txn();   // R6/R7: all ones, unipolar
        send(3'd0, 2'b00, 12'h000);                 // R10: illegal inputs
        send(3'd5, 2'b01, 12'h000);
        send(3'd7, 2'b11, 12'h000);
        repeat (3) @(negedge clk);
        send(3'd4, 2'b00, 12'h123);                 // R9: second request held while busy
        send(3'd3, 2'b11, 12'hF0F);
        finish_txn();
        repeat (20) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule